// File: doc/BRIEF.md
# Serial-to-16-bit deserializer with word clock

This block turns a serial bit stream into 16-bit parallel words. The stream arrives already retimed, one bit per cycle of the bit-rate clock. Every sixteen bits the block moves a complete word into its output register and raises a one-cycle strobe. It also produces a word-rate clock and the complement of that clock, both made by dividing the bit clock by sixteen. Each output clock is driven from its own register.

Bit order is fixed. The bit received first in a group lands on output bit 0, and the block treats bit 0 as the most significant bit. The last bit of the group lands on output bit 15. The output word changes on the rising edge of the complemented word clock. A downstream device that captures on the rising edge of the true word clock therefore samples in the middle of each word period. The block does no framing and no alignment to byte or frame boundaries. The first bit after reset starts the first word.

Top module: `deser16_top`

## Requirements
- R1: While reset is high, and on the first sample after a reset, `word_o` is 0, `valid_o` is 0, `wclk_o` is 0 and `wclk_n_o` is 1.
- R2: The first complete word is presented on the 16th rising bit-clock edge after reset is released, and one word follows every 16 edges after that.
- R3: The serial bit sampled first in a group appears on `word_o[0]` (the MSB), and the k-th sampled bit appears on `word_o[k-1]`, up to the 16th on `word_o[15]`.
- R4: Between updates `word_o` holds the previous complete word, so bits of a group that is still filling never reach the output.
- R5: `valid_o` is high for exactly one bit-clock cycle per word. That cycle is the one in which `word_o` takes its new value.
- R6: `wclk_o` falls in the same cycle as each word update. Apart from the first period after reset, it is then low for 8 cycles and high for 8 cycles.
- R7: `wclk_n_o` is always the complement of `wclk_o`, and it rises exactly when a new word appears.
- R8: A reset applied part way through a group discards the bits gathered so far. The next word is built only from the 16 bits that follow the release of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock; each rising edge samples one serial bit |
| rst | input | 1 | Synchronous active-high reset |
| sdata_i | input | 1 | Retimed serial data |
| word_o | output | 16 | Parallel word; bit 0 holds the earliest bit of the group (MSB) |
| valid_o | output | 1 | One-cycle strobe marking a word update |
| wclk_o | output | 1 | Word clock, bit clock divided by 16 |
| wclk_n_o | output | 1 | Complement of the word clock; rises on each word update |

## Verification
The bit sampled at a given edge is counted as position k of its group. The word that position 15 completes is visible right after that same edge, together with the strobe and the falling word clock. There is no further cycle of latency. The bench changes the serial input on the falling edge and reads every output on the next falling edge. Each read therefore reflects exactly one rising edge, and the expected word-clock level is a function of k alone. The partial-group and mid-word-reset cases check that the output and the clocks move only at these computed cycles.

// File: rtl/deser_pkg.sv
package deser_pkg;

  // Word clock and its complement, each driven from its own register.
  typedef struct packed {
    logic wclk;
    logic wclk_n;
  } wclk_pair_t;

endpackage

// File: rtl/deser_bit_ctr.sv
// Position counter inside the current group of serial bits.
module deser_bit_ctr #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_o    = (cnt_q == LAST_POS);
  assign cnt_nxt_o = last_o ? '0 : cnt_q + 1'b1;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt_o;
  end

  // R2: the group boundary wraps back to position zero
  assert_ctr_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    last_o |=> (cnt_q == '0));

endmodule

// File: rtl/deser_shift.sv
// Gathers serial bits (earliest at bit 0) and loads the full word at once.
module deser_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdata_i,
  input  logic              load_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);

  // Holds the first WORD_W-1 bits; the last bit goes straight to the load.
  logic [WORD_W-2:0] shreg_q;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      shreg_q <= {sdata_i, shreg_q[WORD_W-2:1]};
      valid_q <= load_i;
      if (load_i) word_q <= {sdata_i, shreg_q};
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  // R4: the output moves only together with the strobe
  assert_word_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> $stable(word_q));

  // R5: the strobe never lasts two cycles
  assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);

endmodule

// File: rtl/deser_wclk.sv
// Word clock: high for the second half of each group, falling at the word load.
module deser_wclk
  import deser_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W),
  localparam int HALF  = WORD_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output wclk_pair_t       pair_o
);

  logic wclk_q;
  logic wclk_n_q;
  logic hi_nxt;

  assign hi_nxt = (cnt_nxt_i >= CNT_W'(HALF));

  always_ff @(posedge clk) begin
    if (rst) begin
      wclk_q   <= 1'b0;
      wclk_n_q <= 1'b1;
    end else begin
      wclk_q   <= hi_nxt;
      wclk_n_q <= ~hi_nxt;
    end
  end

  assign pair_o.wclk   = wclk_q;
  assign pair_o.wclk_n = wclk_n_q;

  // R7: the two clock registers never agree
  assert_wclk_compl_R7: assert property (@(posedge clk) disable iff (rst)
    wclk_q != wclk_n_q);

endmodule

// File: rtl/deser16_top.sv
// Serial-to-parallel converter with divided word clocks.
// WORD_W must be a power of two and at least 4.
module deser16_top
  import deser_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W),
  localparam int HALF  = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              wclk_o,
  output logic              wclk_n_o
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             last;
  wclk_pair_t       pair;

  deser_bit_ctr #(.WORD_W(WORD_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .last_o    (last)
  );

  deser_shift #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .sdata_i (sdata_i),
    .load_i  (last),
    .word_o  (word_o),
    .valid_o (valid_o)
  );

  deser_wclk #(.WORD_W(WORD_W)) u_wclk (
    .clk       (clk),
    .rst       (rst),
    .cnt_nxt_i (cnt_nxt),
    .pair_o    (pair)
  );

  assign wclk_o   = pair.wclk;
  assign wclk_n_o = pair.wclk_n;

  // R2: a word is presented only as the position counter restarts
  assert_valid_boundary_R2: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (cnt == '0));

  // R6: the word clock falls with every load
  assert_wclk_fall_R6: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $fell(wclk_o));

  // R6: the word clock rises halfway through a group
  assert_wclk_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(wclk_o) |-> (cnt == CNT_W'(HALF)));

  // R7: the complemented clock rises only when a word appears
  assert_wclkn_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(wclk_n_o) |-> valid_o);

endmodule

// File: tb/tb_deser16_top.sv
module tb_deser16_top;

  localparam int W = 16;
  localparam int NV = 8;
  localparam logic [W-1:0] VEC [NV] = '{
    16'h0001, 16'h8000, 16'h1234, 16'hA5C3,
    16'hFFFE, 16'h0F00, 16'h3C5A, 16'hFFFF
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdata = 1'b0;
  logic [W-1:0] word;
  logic valid, wclk, wclk_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  deser16_top #(.WORD_W(W)) dut (
    .clk      (clk),
    .rst      (rst),
    .sdata_i  (sdata),
    .word_o   (word),
    .valid_o  (valid),
    .wclk_o   (wclk),
    .wclk_n_o (wclk_n)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic chk_reset_state();
    chk("R1 word", word, '0);
    chk("R1 valid", W'(valid), '0);
    chk("R1 wclk", W'(wclk), '0);
    chk("R1 wclk_n", W'(wclk_n), W'(1));
  endtask

  // Sends v earliest bit first. The sample after bit k reflects one posedge
  // taken at position k.
  task automatic run_word(input logic [W-1:0] v, input logic [W-1:0] prev, input string req);
    for (int k = 0; k < W; k++) begin
      logic hi;
      sdata = v[k];
      @(negedge clk);
      hi = (k >= W/2 - 1) && (k <= W - 2);
      chk("R6 wclk level", W'(wclk), W'(hi));
      chk("R7 wclk_n level", W'(wclk_n), W'(!hi));
      if (k == W - 1) begin
        chk("R5 valid on update", W'(valid), W'(1));
        chk(req, word, v);  // R3 order and R2 timing
      end else begin
        chk("R5 valid low", W'(valid), '0);
        chk("R4 hold", word, prev);
      end
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] prev;
    repeat (3) @(negedge clk);
    chk_reset_state();  // R1
    rst = 1'b0;
    prev = '0;
    for (int i = 0; i < NV; i++) begin
      run_word(VEC[i], prev, "R3 bit order / R2 timing");
      prev = VEC[i];
    end

    // Partial group, then reset in the middle of it (R4, R8)
    for (int k = 0; k < 5; k++) begin
      sdata = 1'b1;
      @(negedge clk);
      chk("R4 partial hidden", word, prev);
      chk("R5 no strobe mid-word", W'(valid), '0);
    end
    rst = 1'b1;
    sdata = 1'b0;
    @(negedge clk);
    chk_reset_state();  // R8 reset clears partial state
    @(negedge clk);
    chk_reset_state();
    rst = 1'b0;
    run_word(16'h6A01, '0, "R8 fresh word after mid-word reset");
    run_word(16'h0180, 16'h6A01, "R3 follow-up word");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule